// File: doc/BRIEF.md
# Linked-Descriptor Output DMA Channel

This block is a single output DMA channel. Software prepares a chain of data descriptors in memory, each naming a byte buffer and the address of the next descriptor. The channel follows the chain and sends the bytes of each buffer to a client as a byte stream. Software controls it through a small register port. The channel reaches memory through a word/byte master port, which it uses to fetch descriptors, read buffer bytes, and write descriptors and the context record back.

The channel moves each buffer in chunks of at most `STAGE` bytes. Each chunk is read into a local staging store and then streamed to the client. A descriptor flagged as the last in the chain stops the channel. At that point the context record is written back with its disabled bit set, so software can see where the walk ended. A later continue command picks up the chain again, provided software has since cleared the last-in-chain flag in the current descriptor.

A data descriptor is four 32-bit words: next pointer (+0x0), buffer start (+0x4), buffer end, exclusive (+0x8), and flags (+0xC). In the flags word, bit 0 marks the end of the chain and bit 1 marks the end of a packet. The context record is three words at the group address: saved descriptor pointer (+0x0), saved buffer pointer (+0x4), and flags (+0x8), where bit 0 is the disabled bit.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset, status reads 0, out_valid is 0 and mem_req is 0.
- R2: The register offsets within the 13-bit window are:
  - 0x00: saved descriptor pointer (read/write).
  - 0x04: current descriptor pointer (read only).
  - 0x08: saved buffer pointer (read/write).
  - 0x0C: group/context address (read/write).
  - 0x10: command (write; reads back its stored low 10 bits).
  - 0x14: status (read only).

  Writes to the pointer registers take effect only while the channel is idle.
- R3: Only bits 9:0 of a command write are decoded. Bit 0 loads a descriptor, bit 1 requests a burst, bit 2 loads the context and bit 3 requests a continue. A command with only bits above 9 set has no effect on status and issues no memory traffic.
- R4: A load command reads the four descriptor words from the saved descriptor pointer and copies that pointer into the current pointer. It leaves the saved buffer pointer unchanged. Without the burst bit the channel stays stopped. With the burst bit it starts streaming from the saved buffer pointer.
- R5: A context-load command reads the three context words from the group address, sets the saved descriptor and saved buffer pointers from them, loads the descriptor and then starts the channel.
- R6: While running, each pass streams min(end − saved buffer pointer, STAGE) bytes in ascending address order, then advances the saved buffer pointer by that count.
- R7: When a buffer is exhausted and the end-of-chain flag is clear, the channel follows the next pointer into both descriptor pointers and fetches that descriptor. It sets the saved buffer pointer to that descriptor's buffer start, writes the four descriptor words back, and continues.
- R8: When a buffer is exhausted and the end-of-chain flag is set, the channel takes these steps in order:
  - It sets the end-of-chain status bit.
  - It writes the three context words to the group address, with flags bit 0 set.
  - It stops.
  - It writes the descriptor back.
- R9: out_eop is asserted with the final byte of a buffer whose end-of-packet flag is set, and only then.
- R10: A continue command acts only when the end-of-chain status bit is set; otherwise it has no effect. When it acts, the channel re-reads the current descriptor. If that descriptor's end-of-chain flag is now clear, the channel follows the next pointer, clears the status bit and runs from the new buffer start. If the flag is still set, it stays stopped, with the saved buffer pointer set to the current descriptor's buffer start.
- R11: While out_ready is low, out_valid, out_data and out_eop hold, and no byte is lost or duplicated.
- R12: The status register has three fields:
  - Bit 0: 1 while the channel is running.
  - Bit 5: the end-of-chain flag.
  - Bits 9:8: the source of the last command acted on (1 = load, 2 = context load, 3 = continue).
- R13: A memory request holds its address, direction and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = word write, 0 = read |
| mem_byte | output | 1 | Byte read; data in mem_rdata[7:0] |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Memory read data |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_eop | output | 1 | Last byte of packet |
| out_ready | input | 1 | Client accepts byte |

## Verification
Register writes take effect at the next clock edge, and register reads are combinational, so the bench samples reads 1 ns after a falling edge. Descriptor walks take a variable number of cycles, because the memory model acknowledges only on alternate cycles and the client stalls one cycle in three. The bench therefore does not count cycles for these. It waits for the running bit to rise and then fall, and allows 20 more cycles for the trailing descriptor write-back before it reads pointers, memory and status. Streamed bytes are checked by a scoreboard at each accepting falling edge, so the check does not depend on when each byte appears.

// File: rtl/dma_desc_chan.sv
module dma_desc_chan #(
  parameter int AW    = 32,
  parameter int STAGE = 4,
  parameter int CMDW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [12:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_eop,
  input  logic          out_ready
);
  localparam int IW = $clog2(STAGE);
  localparam int LW = IW + 1;
  localparam logic [12:0] A_SDP = 13'h00, A_CUR = 13'h04, A_SBP = 13'h08,
                          A_GRP = 13'h0C, A_CMD = 13'h10, A_STAT = 13'h14;

  typedef enum logic [2:0] {S_IDLE, S_CRD, S_DRD, S_CHK, S_BRD, S_PUSH, S_CWB, S_DWB} st_t;
  typedef enum logic [2:0] {P_STOP, P_RUN, P_STEP, P_CONT, P_RESUME} post_t;

  st_t   st;
  post_t post;
  logic [AW-1:0] sdp, cur, sbp, gdown, d_next, d_buf, d_after;
  logic [31:0]   d_flags, c_flags;
  logic [CMDW-1:0] cmd_q;
  logic [1:0]    src, widx;
  logic          run, eol_f;
  logic [IW-1:0] bcnt;
  logic [LW-1:0] blen;
  logic [7:0]    stage [STAGE];

  logic          idle, cmd_hit, last_b, buf_end;
  logic [AW-1:0] rem;
  logic [LW-1:0] clen;
  logic [CMDW-1:0] cmd;

  assign idle    = (st == S_IDLE);
  assign cmd     = reg_wdata[CMDW-1:0];
  assign cmd_hit = reg_wr && reg_addr == A_CMD && idle;
  assign rem     = d_after - sbp;
  assign clen    = (rem >= AW'(STAGE)) ? LW'(STAGE) : rem[LW-1:0];
  assign last_b  = (LW'(bcnt) + LW'(1)) == blen;
  assign buf_end = (sbp + AW'(blen)) == d_after;

  assign mem_req   = st inside {S_CRD, S_DRD, S_BRD, S_CWB, S_DWB};
  assign mem_we    = st inside {S_CWB, S_DWB};
  assign mem_byte  = (st == S_BRD);
  assign out_valid = (st == S_PUSH);
  assign out_data  = stage[bcnt];
  assign out_eop   = out_valid && last_b && d_flags[1] && buf_end;

  always_comb begin
    case (st)
      S_CRD, S_CWB: mem_addr = gdown + AW'({widx, 2'b00});
      S_BRD:        mem_addr = sbp + AW'(bcnt);
      default:      mem_addr = cur + AW'({widx, 2'b00});
    endcase
  end

  always_comb begin
    mem_wdata = '0;
    if (st == S_CWB) begin
      case (widx)
        2'd0:    mem_wdata = 32'(sdp);
        2'd1:    mem_wdata = 32'(sbp);
        default: mem_wdata = c_flags;
      endcase
    end else if (st == S_DWB) begin
      case (widx)
        2'd0:    mem_wdata = 32'(d_next);
        2'd1:    mem_wdata = 32'(d_buf);
        2'd2:    mem_wdata = 32'(d_after);
        default: mem_wdata = d_flags;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_SDP:   reg_rdata = 32'(sdp);
      A_CUR:   reg_rdata = 32'(cur);
      A_SBP:   reg_rdata = 32'(sbp);
      A_GRP:   reg_rdata = 32'(gdown);
      A_CMD:   reg_rdata = 32'(cmd_q);
      A_STAT:  reg_rdata = {22'd0, src, 2'd0, eol_f, 4'd0, run};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; post <= P_STOP;
      sdp <= '0; cur <= '0; sbp <= '0; gdown <= '0;
      d_next <= '0; d_buf <= '0; d_after <= '0; d_flags <= '0; c_flags <= '0;
      cmd_q <= '0; src <= '0; widx <= '0; run <= 1'b0; eol_f <= 1'b0;
      bcnt <= '0; blen <= '0;
      for (int i = 0; i < STAGE; i++) stage[i] <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CMD) cmd_q <= cmd;
      if (reg_wr && idle) begin
        case (reg_addr)
          A_SDP: sdp   <= reg_wdata[AW-1:0];
          A_SBP: sbp   <= reg_wdata[AW-1:0];
          A_GRP: gdown <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (cmd_hit) begin
          widx <= '0;
          if (cmd[2]) begin
            src <= 2'd2; st <= S_CRD;
          end else if (cmd[0]) begin
            src <= 2'd1; cur <= sdp; st <= S_DRD;
            post <= cmd[1] ? P_RUN : P_STOP;
          end else if (cmd[3] && eol_f) begin
            src <= 2'd3; post <= P_CONT; st <= S_DRD;
          end
        end
        S_CRD: if (mem_ack) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: sdp <= mem_rdata[AW-1:0];
            2'd1: sbp <= mem_rdata[AW-1:0];
            default: begin
              c_flags <= mem_rdata;
              cur <= sdp; widx <= '0; post <= P_RUN; st <= S_DRD;
            end
          endcase
        end
        S_DRD: if (mem_ack) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: d_next  <= mem_rdata[AW-1:0];
            2'd1: d_buf   <= mem_rdata[AW-1:0];
            2'd2: d_after <= mem_rdata[AW-1:0];
            default: begin
              d_flags <= mem_rdata;
              case (post)
                P_RUN:  begin run <= 1'b1; st <= S_CHK; end
                P_STEP: begin sbp <= d_buf; st <= S_DWB; end
                P_CONT: begin
                  if (!mem_rdata[0]) begin
                    sdp <= d_next; cur <= d_next; post <= P_RESUME;
                  end else begin
                    sbp <= d_buf; st <= S_IDLE;
                  end
                end
                P_RESUME: begin
                  sbp <= d_buf; eol_f <= 1'b0; run <= 1'b1; st <= S_CHK;
                end
                default: st <= S_IDLE;
              endcase
            end
          endcase
        end
        S_CHK: begin
          widx <= '0; bcnt <= '0;
          if (sbp == d_after) begin
            if (d_flags[0]) begin
              eol_f <= 1'b1; c_flags <= c_flags | 32'd1; st <= S_CWB;
            end else begin
              sdp <= d_next; cur <= d_next; post <= P_STEP; st <= S_DRD;
            end
          end else begin
            blen <= clen; st <= S_BRD;
          end
        end
        S_BRD: if (mem_ack) begin
          stage[bcnt] <= mem_rdata[7:0];
          if (last_b) begin bcnt <= '0; st <= S_PUSH; end
          else bcnt <= bcnt + IW'(1);
        end
        S_PUSH: if (out_ready) begin
          if (last_b) begin sbp <= sbp + AW'(blen); st <= S_CHK; end
          else bcnt <= bcnt + IW'(1);
        end
        S_CWB: if (mem_ack) begin
          if (widx == 2'd2) begin widx <= '0; run <= 1'b0; st <= S_DWB; end
          else widx <= widx + 2'd1;
        end
        S_DWB: if (mem_ack) begin
          widx <= widx + 2'd1;
          if (widx == 2'd3) st <= run ? S_CHK : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_desc_chan_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [AW-1:0] gdown,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_eop,
  input logic [7:0]    out_data,
  input logic          eol_f,
  input logic          run
);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop));
  // R8
  eol_ctx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eol_f) |-> mem_req && mem_we && mem_addr == gdown);
  // R8
  stop_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(mem_we && mem_ack));
  // R9
  eop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);
endmodule

bind dma_desc_chan dma_desc_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .gdown(gdown), .out_valid(out_valid),
  .out_ready(out_ready), .out_eop(out_eop), .out_data(out_data), .eol_f(eol_f), .run(run)
);

// File: tb/dma_desc_chan_test.sv
`timescale 1ns/1ps
module dma_desc_chan_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [12:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_byte, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic out_valid, out_eop, out_ready;
  logic [7:0] out_data;
  logic [7:0] m [1024];
  logic ack_ph = 0;
  int rdy_cnt = 0, checks = 0, fails = 0, reqs = 0, writes = 0;
  logic [8:0] expq [$];
  logic st_prev = 0;
  logic [8:0] st_val = 0;

  always #10 clk = ~clk;

  dma_desc_chan uut (.*);

  function automatic logic [31:0] get32(input int a);
    return {m[(a+3)&1023], m[(a+2)&1023], m[(a+1)&1023], m[a&1023]};
  endfunction
  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) m[(a+i)&1023] = v[8*i +: 8];
  endtask
  function automatic logic [7:0] bval(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  assign mem_ack   = mem_req & ack_ph;
  assign mem_rdata = mem_byte ? {24'd0, m[mem_addr[9:0]]} : get32(int'(mem_addr[9:0]));
  assign out_ready = (rdy_cnt % 3) != 0;

  always @(posedge clk) begin
    ack_ph <= ~ack_ph;
    rdy_cnt <= rdy_cnt + 1;
    if (mem_req) reqs <= reqs + 1;
    if (mem_req && mem_we && mem_ack) begin
      put32(int'(mem_addr[9:0]), mem_wdata);
      writes <= writes + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (st_prev) chk(out_valid && {out_eop, out_data} == st_val, "R11 stall hold", {out_eop, out_data}, st_val);
    st_prev = out_valid && !out_ready;
    st_val = {out_eop, out_data};
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R6 unexpected byte", {out_eop, out_data}, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({out_eop, out_data} == e, "R6/R9 stream byte", {out_eop, out_data}, e);
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic push_exp(input int s, input int n, input bit eop);
    for (int i = 0; i < n; i++) expq.push_back({eop && i == n-1, bval(s+i)});
  endtask
  task automatic wait_run_stop;
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin rd(13'h14, s); if (s[0]) break; end
    for (int i = 0; i < 6000; i++) begin rd(13'h14, s); if (!s[0]) break; end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0, w0;
    for (int i = 0; i < 1024; i++) m[i] = bval(i);
    put32(12'h100, 32'h120); put32(12'h104, 32'h200); put32(12'h108, 32'h206); put32(12'h10C, 32'h2);
    put32(12'h120, 32'h140); put32(12'h124, 32'h240); put32(12'h128, 32'h243); put32(12'h12C, 32'h3);
    put32(12'h140, 32'h0);   put32(12'h144, 32'h260); put32(12'h148, 32'h265); put32(12'h14C, 32'h3);
    put32(12'h180, 32'h100); put32(12'h184, 32'h200); put32(12'h188, 32'h0);
    repeat (3) @(negedge clk);
    // R1
    rd(13'h14, v); chk(v == 0, "R1 status", v, 0);
    chk(!out_valid && !mem_req, "R1 outputs idle", {out_valid, mem_req}, 0);
    rst_n = 1;
    rd(13'h14, v); chk(v == 0, "R1 status after release", v, 0);

    // R2
    wr(13'h00, 32'h100); rd(13'h00, v); chk(v == 32'h100, "R2 saved ptr", v, 32'h100);
    wr(13'h08, 32'h77);  rd(13'h08, v); chk(v == 32'h77, "R2 saved buf", v, 32'h77);
    wr(13'h0C, 32'h180); rd(13'h0C, v); chk(v == 32'h180, "R2 group addr", v, 32'h180);

    // R3: only high bits set
    r0 = reqs;
    wr(13'h10, 32'hFFFF_FC00); repeat (10) @(negedge clk);
    rd(13'h14, v); chk(v == 0, "R3 high bits no effect status", v, 0);
    chk(reqs == r0, "R3 high bits no memory traffic", reqs, r0);
    rd(13'h10, v); chk(v == 0, "R3 stored low bits", v, 0);

    // R10: continue outside end-of-chain
    r0 = reqs;
    wr(13'h10, 32'h8); repeat (10) @(negedge clk);
    rd(13'h14, v); chk(v == 0, "R10 continue ignored status", v, 0);
    chk(reqs == r0, "R10 continue ignored traffic", reqs, r0);

    // R4: load without burst
    wr(13'h10, 32'h1); repeat (30) @(negedge clk);
    rd(13'h04, v); chk(v == 32'h100, "R4 current ptr", v, 32'h100);
    rd(13'h08, v); chk(v == 32'h77, "R4 saved buf untouched", v, 32'h77);
    rd(13'h14, v); chk(v == 32'h100, "R4 R12 stopped status", v, 32'h100);
    chk(expq.size() == 0 && !out_valid, "R4 no stream", out_valid, 0);

    // R5 R6 R7 R8 R9: context load, two descriptors
    push_exp(12'h200, 6, 1); push_exp(12'h240, 3, 1);
    w0 = writes;
    wr(13'h10, 32'h4); wait_run_stop;
    chk(expq.size() == 0, "R6 all bytes sent", expq.size(), 0);
    rd(13'h14, v); chk(v == 32'h220, "R8 R12 status", v, 32'h220);
    rd(13'h04, v); chk(v == 32'h120, "R7 current ptr", v, 32'h120);
    rd(13'h08, v); chk(v == 32'h243, "R6 saved buf end", v, 32'h243);
    chk(get32(12'h180) == 32'h120, "R8 ctx word0", get32(12'h180), 32'h120);
    chk(get32(12'h184) == 32'h243, "R8 ctx word1", get32(12'h184), 32'h243);
    chk(get32(12'h188) == 32'h1, "R8 ctx disabled bit", get32(12'h188), 1);
    chk(writes - w0 == 11, "R7 R8 write-back count", writes - w0, 11);

    // R10: continue with flag still set
    wr(13'h10, 32'h8); repeat (30) @(negedge clk);
    rd(13'h14, v); chk(v == 32'h320, "R10 still stopped", v, 32'h320);
    rd(13'h08, v); chk(v == 32'h240, "R10 buf refreshed", v, 32'h240);

    // R10: continue after flag cleared
    put32(12'h12C, 32'h0);
    put32(12'h180, 0); put32(12'h184, 0); put32(12'h188, 0);
    push_exp(12'h260, 5, 1);
    w0 = writes;
    wr(13'h10, 32'h8); wait_run_stop;
    chk(expq.size() == 0, "R10 resumed bytes sent", expq.size(), 0);
    rd(13'h14, v); chk(v == 32'h320, "R10 R8 status", v, 32'h320);
    rd(13'h04, v); chk(v == 32'h140, "R10 current ptr", v, 32'h140);
    chk(get32(12'h180) == 32'h140, "R8 ctx word0 again", get32(12'h180), 32'h140);
    chk(get32(12'h184) == 32'h265, "R8 ctx word1 again", get32(12'h184), 32'h265);
    chk(get32(12'h188) == 32'h1, "R8 ctx disabled again", get32(12'h188), 1);
    chk(writes - w0 == 7, "R8 write count", writes - w0, 7);

    // R4: load with burst keeps software-set buffer pointer
    wr(13'h08, 32'h262);
    push_exp(12'h262, 3, 1);
    wr(13'h10, 32'h3); wait_run_stop;
    chk(expq.size() == 0, "R4 burst bytes sent", expq.size(), 0);
    rd(13'h14, v); chk(v == 32'h120, "R4 R12 burst status", v, 32'h120);
    rd(13'h08, v); chk(v == 32'h265, "R6 buf after burst", v, 32'h265);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule